// File: doc/BRIEF.md
# Multi-Bank Memory Router with Broadcast

The router sits between a set of small shared memory banks and three kinds of requester. The requesters are one master processor, one worker processor for each non-home bank, and a streaming port that moves frames in or out. Each bank has a two-bit owner field, so at any moment exactly one requester class can reach it. Different banks may have different owners at the same time. Because ownership removes contention, there is no arbitration. Bank 0 is the master's home bank. Banks 1 to NB-1 are each paired with one worker.

The master address has three fields. The top two bits pick a region. The next BSW bits pick a bank. The low AW bits are the word offset. With this layout the master can use its local window, address every bank in a linear array, or write the same word into many banks through one of two broadcast windows. One broadcast window skips the home bank, so the master can read its own bank while it fans data out to the others.

In receive direction the stream port writes every bank it owns. In transmit direction it reads the one bank it owns. A new configuration (owners, broadcast enables, stream direction) is presented on a one-cycle strobe. It is committed only on a clock edge with no access in progress.

Top module: `mbank_router`

## Requirements
- R1: After reset every bank has owner code 0 (own processor), all broadcast enables are clear, the stream direction is receive, and every valid and error output is low.
- R2: A master access with region code 0 reaches bank 0 at the given offset when bank 0 has owner code 0 or 1. Read data appears with `m_rvalid_o` one cycle after the request.
- R3: A master access with region code 1 reaches bank n (bank field = n) when bank n has owner code 1. Bank 0 is also reached with owner code 0. A bank field of NB or more is an error.
- R4: Worker n reaches bank n only when the address bits above the offset are all zero and bank n has owner code 0. Any other worker access is an error. Read data arrives with `w_rvalid_o[n]` one cycle later.
- R5: An access to a bank the requester does not own performs no write. One cycle later it raises the error output for one cycle. A read also pulses its valid output with zero data.
- R6: A master write with region code 2 lands at the same offset in every bank whose broadcast enable bit is set and which the master owns, bank 0 included.
- R7: A master write with region code 3 behaves like region 2 but never touches bank 0.
- R8: A master read with region code 2 or 3 returns zero data and raises `m_err_o`.
- R9: In receive direction (`cfg_tx_i`=0) a stream write stores the word in every bank with owner code 2.
- R10: In transmit direction a stream read returns the addressed word of the single bank with owner code 2, one cycle later with `st_rvalid_o`. If no bank has owner code 2 the read returns zero.
- R11: A configuration in transmit direction with more than one bank of owner code 2 is rejected. The previous configuration stays in force, and `cfg_err_o` pulses one cycle after the commit edge.
- R12: A configuration is committed on the first clock edge at which no request is active, starting with the strobe's own edge. Requests issued before that edge use the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | New configuration strobe |
| cfg_mode_i | input | NB*2 | Owner code per bank: 0 own processor, 1 master, 2 stream, 3 none |
| cfg_bcast_i | input | NB | Broadcast enable per bank |
| cfg_tx_i | input | 1 | Stream direction, 1 = transmit |
| cfg_err_o | output | 1 | Rejected configuration pulse |
| m_req_i | input | 1 | Master request |
| m_we_i | input | 1 | Master write enable |
| m_addr_i | input | 2+BSW+AW | Master address {region, bank, offset} |
| m_wdata_i | input | DW | Master write data |
| m_rdata_o | output | DW | Master read data |
| m_rvalid_o | output | 1 | Master read return |
| m_err_o | output | 1 | Master access error pulse |
| w_req_i | input | NB-1 | Worker requests, index 1..NB-1 |
| w_we_i | input | NB-1 | Worker write enables |
| w_addr_i | input | (NB-1)*(2+BSW+AW) | Worker addresses |
| w_wdata_i | input | (NB-1)*DW | Worker write data |
| w_rdata_o | output | (NB-1)*DW | Worker read data |
| w_rvalid_o | output | NB-1 | Worker read returns |
| w_err_o | output | NB-1 | Worker access error pulses |
| st_valid_i | input | 1 | Stream word strobe |
| st_addr_i | input | AW | Stream word offset |
| st_wdata_i | input | DW | Stream receive data |
| st_rdata_o | output | DW | Stream transmit data |
| st_rvalid_o | output | 1 | Stream transmit data valid |

## Verification
The assertions check several properties on every cycle. The owner field never changes while a request is present. A rejected configuration leaves the owners untouched. Transmit direction never has two source banks. Every read, whether master, broadcast-window or stream, returns on the next cycle, and errored master returns carry zero data. Bad worker addresses always produce a worker error. The bench scenarios are needed for the data itself. They show that broadcast writes reach exactly the enabled and owned banks, with the home bank skipped in region 3. They show that unowned writes leave memory unchanged, that receive mode fans out, and that transmit reads the right bank. They also show that a strobe arriving during an access is deferred to the next idle edge.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  localparam logic [1:0] OWN_LOCAL  = 2'd0;
  localparam logic [1:0] OWN_MASTER = 2'd1;
  localparam logic [1:0] OWN_STREAM = 2'd2;
  localparam logic [1:0] OWN_NONE   = 2'd3;

  localparam logic [1:0] RG_LOCAL   = 2'd0;
  localparam logic [1:0] RG_ARRAY   = 2'd1;
  localparam logic [1:0] RG_BC_ALL  = 2'd2;
  localparam logic [1:0] RG_BC_PEER = 2'd3;

  function automatic logic master_owns(input logic [1:0] mode, input logic is_home);
    return (mode == OWN_MASTER) || (is_home && mode == OWN_LOCAL);
  endfunction
endpackage

// File: rtl/mbr_cfg.sv
module mbr_cfg
  import mbr_pkg::*;
#(
  parameter int NB = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                busy_i,
  input  logic                cfg_valid_i,
  input  logic [NB-1:0][1:0]  cfg_mode_i,
  input  logic [NB-1:0]       cfg_bcast_i,
  input  logic                cfg_tx_i,
  output logic [NB-1:0][1:0]  mode_o,
  output logic [NB-1:0]       bcast_o,
  output logic                tx_o,
  output logic                err_o
);
  logic               pend_q;
  logic [NB-1:0][1:0] sh_mode_q;
  logic [NB-1:0]      sh_bcast_q;
  logic               sh_tx_q;
  logic [NB-1:0][1:0] src_mode;
  logic [NB-1:0]      src_bcast;
  logic               src_tx;
  logic               commit, bad;
  int                 n_stream;

  assign src_mode  = cfg_valid_i ? cfg_mode_i  : sh_mode_q;
  assign src_bcast = cfg_valid_i ? cfg_bcast_i : sh_bcast_q;
  assign src_tx    = cfg_valid_i ? cfg_tx_i    : sh_tx_q;
  assign commit    = (cfg_valid_i | pend_q) & ~busy_i;

  always_comb begin
    n_stream = 0;
    for (int b = 0; b < NB; b++)
      if (src_mode[b] == OWN_STREAM) n_stream = n_stream + 1;
    bad = src_tx && (n_stream > 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      sh_mode_q  <= '0;
      sh_bcast_q <= '0;
      sh_tx_q    <= 1'b0;
      mode_o     <= '0;
      bcast_o    <= '0;
      tx_o       <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (cfg_valid_i && busy_i) begin
        // park until the ports go idle
        pend_q     <= 1'b1;
        sh_mode_q  <= cfg_mode_i;
        sh_bcast_q <= cfg_bcast_i;
        sh_tx_q    <= cfg_tx_i;
      end else if (commit) begin
        pend_q <= 1'b0;
        if (bad) begin
          err_o <= 1'b1;
        end else begin
          mode_o  <= src_mode;
          bcast_o <= src_bcast;
          tx_o    <= src_tx;
        end
      end
    end
  end
endmodule

// File: rtl/mbr_decode.sv
module mbr_decode
  import mbr_pkg::*;
#(
  parameter int NB  = 9,
  parameter int AW  = 4,
  localparam int BSW = $clog2(NB),
  localparam int MAW = 2 + BSW + AW
) (
  input  logic               req_i,
  input  logic               we_i,
  input  logic [MAW-1:0]     addr_i,
  input  logic [NB-1:0][1:0] mode_i,
  input  logic [NB-1:0]      bcast_i,
  output logic [NB-1:0]      sel_o,
  output logic               err_o,
  output logic [BSW-1:0]     rd_bank_o
);
  logic [1:0]     region;
  logic [BSW-1:0] bsel;

  assign region = addr_i[MAW-1 -: 2];
  assign bsel   = addr_i[AW +: BSW];

  always_comb begin
    sel_o     = '0;
    err_o     = 1'b0;
    rd_bank_o = '0;
    unique case (region)
      RG_LOCAL: begin
        if (master_owns(mode_i[0], 1'b1)) sel_o[0] = 1'b1;
        else                              err_o    = 1'b1;
      end
      RG_ARRAY: begin
        err_o = 1'b1;
        for (int b = 0; b < NB; b++) begin
          if (bsel == BSW'(b) && master_owns(mode_i[b], b == 0)) begin
            sel_o[b]  = 1'b1;
            err_o     = 1'b0;
            rd_bank_o = BSW'(b);
          end
        end
      end
      default: begin
        // broadcast windows accept writes only
        err_o = ~we_i;
        if (we_i) begin
          for (int b = 0; b < NB; b++)
            sel_o[b] = bcast_i[b] && master_owns(mode_i[b], b == 0)
                       && !(region == RG_BC_PEER && b == 0);
        end
      end
    endcase
    if (!req_i) begin
      sel_o = '0;
      err_o = 1'b0;
    end
  end
endmodule

// File: rtl/mbr_bank.sv
module mbr_bank
  import mbr_pkg::*;
#(
  parameter int AW   = 4,
  parameter int DW   = 16,
  parameter bit HOME = 1'b0,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic [1:0]    mode_i,
  input  logic          m_sel_i,
  input  logic          m_we_i,
  input  logic [AW-1:0] m_off_i,
  input  logic [DW-1:0] m_wdata_i,
  input  logic          w_sel_i,
  input  logic          w_we_i,
  input  logic [AW-1:0] w_off_i,
  input  logic [DW-1:0] w_wdata_i,
  input  logic          s_sel_i,
  input  logic          s_we_i,
  input  logic [AW-1:0] s_off_i,
  input  logic [DW-1:0] s_wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];
  logic          en, we;
  logic [AW-1:0] off;
  logic [DW-1:0] wd;

  // the owner field alone picks the port
  always_comb begin
    en  = 1'b0;
    we  = 1'b0;
    off = m_off_i;
    wd  = m_wdata_i;
    if (master_owns(mode_i, HOME)) begin
      en = m_sel_i; we = m_we_i;
    end else if (mode_i == OWN_LOCAL) begin
      en = w_sel_i; we = w_we_i; off = w_off_i; wd = w_wdata_i;
    end else if (mode_i == OWN_STREAM) begin
      en = s_sel_i; we = s_we_i; off = s_off_i; wd = s_wdata_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (en && we)  mem[off] <= wd;
    if (en && !we) rdata_o  <= mem[off];
  end
endmodule

// File: rtl/mbank_router.sv
module mbank_router
  import mbr_pkg::*;
#(
  parameter int NB  = 9,
  parameter int AW  = 4,
  parameter int DW  = 16,
  localparam int BSW = $clog2(NB),
  localparam int MAW = 2 + BSW + AW
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_valid_i,
  input  logic [NB-1:0][1:0]      cfg_mode_i,
  input  logic [NB-1:0]           cfg_bcast_i,
  input  logic                    cfg_tx_i,
  output logic                    cfg_err_o,
  input  logic                    m_req_i,
  input  logic                    m_we_i,
  input  logic [MAW-1:0]          m_addr_i,
  input  logic [DW-1:0]           m_wdata_i,
  output logic [DW-1:0]           m_rdata_o,
  output logic                    m_rvalid_o,
  output logic                    m_err_o,
  input  logic [NB-1:1]           w_req_i,
  input  logic [NB-1:1]           w_we_i,
  input  logic [NB-1:1][MAW-1:0]  w_addr_i,
  input  logic [NB-1:1][DW-1:0]   w_wdata_i,
  output logic [NB-1:1][DW-1:0]   w_rdata_o,
  output logic [NB-1:1]           w_rvalid_o,
  output logic [NB-1:1]           w_err_o,
  input  logic                    st_valid_i,
  input  logic [AW-1:0]           st_addr_i,
  input  logic [DW-1:0]           st_wdata_i,
  output logic [DW-1:0]           st_rdata_o,
  output logic                    st_rvalid_o
);
  logic [NB-1:0][1:0]  mode_q;
  logic [NB-1:0]       bcast_q;
  logic                tx_q;
  logic                busy;
  logic [NB-1:0]       m_sel;
  logic                m_err_c;
  logic [BSW-1:0]      m_bank_c, m_bank_q;
  logic                m_rv_q, m_ok_q, m_err_q;
  logic [NB-1:1]       w_hit, w_rv_q, w_ok_q, w_err_q;
  logic [NB-1:0][DW-1:0] bank_rdata;
  logic                st_any;
  logic [BSW-1:0]      st_idx, st_idx_q;
  logic                st_rv_q, st_ok_q;

  assign busy = m_req_i | (|w_req_i) | st_valid_i;

  mbr_cfg #(.NB(NB)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy),
    .cfg_valid_i (cfg_valid_i),
    .cfg_mode_i  (cfg_mode_i),
    .cfg_bcast_i (cfg_bcast_i),
    .cfg_tx_i    (cfg_tx_i),
    .mode_o      (mode_q),
    .bcast_o     (bcast_q),
    .tx_o        (tx_q),
    .err_o       (cfg_err_o)
  );

  mbr_decode #(.NB(NB), .AW(AW)) u_dec (
    .req_i     (m_req_i),
    .we_i      (m_we_i),
    .addr_i    (m_addr_i),
    .mode_i    (mode_q),
    .bcast_i   (bcast_q),
    .sel_o     (m_sel),
    .err_o     (m_err_c),
    .rd_bank_o (m_bank_c)
  );

  for (genvar n = 1; n < NB; n++) begin : g_worker
    assign w_hit[n] = w_req_i[n] && (w_addr_i[n][MAW-1:AW] == '0)
                      && (mode_q[n] == OWN_LOCAL);
    assign w_rdata_o[n] = w_ok_q[n] ? bank_rdata[n] : '0;
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic          wsel, wwe;
    logic [AW-1:0] woff;
    logic [DW-1:0] wwd;
    if (b == 0) begin : g_home
      assign wsel = 1'b0;
      assign wwe  = 1'b0;
      assign woff = '0;
      assign wwd  = '0;
    end else begin : g_peer
      assign wsel = w_hit[b];
      assign wwe  = w_we_i[b];
      assign woff = w_addr_i[b][AW-1:0];
      assign wwd  = w_wdata_i[b];
    end
    mbr_bank #(.AW(AW), .DW(DW), .HOME(b == 0)) u_bank (
      .clk_i     (clk_i),
      .mode_i    (mode_q[b]),
      .m_sel_i   (m_sel[b]),
      .m_we_i    (m_we_i),
      .m_off_i   (m_addr_i[AW-1:0]),
      .m_wdata_i (m_wdata_i),
      .w_sel_i   (wsel),
      .w_we_i    (wwe),
      .w_off_i   (woff),
      .w_wdata_i (wwd),
      .s_sel_i   (st_valid_i),
      .s_we_i    (~tx_q),
      .s_off_i   (st_addr_i),
      .s_wdata_i (st_wdata_i),
      .rdata_o   (bank_rdata[b])
    );
  end

  // transmit source: at most one stream bank exists once committed
  always_comb begin
    st_any = 1'b0;
    st_idx = '0;
    for (int b = 0; b < NB; b++) begin
      if (mode_q[b] == OWN_STREAM) begin
        st_any = 1'b1;
        st_idx = BSW'(b);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rv_q   <= 1'b0;
      m_ok_q   <= 1'b0;
      m_err_q  <= 1'b0;
      m_bank_q <= '0;
      w_rv_q   <= '0;
      w_ok_q   <= '0;
      w_err_q  <= '0;
      st_rv_q  <= 1'b0;
      st_ok_q  <= 1'b0;
      st_idx_q <= '0;
    end else begin
      m_rv_q   <= m_req_i & ~m_we_i;
      m_ok_q   <= m_req_i & ~m_we_i & ~m_err_c;
      m_err_q  <= m_err_c;
      m_bank_q <= m_bank_c;
      w_rv_q   <= w_req_i & ~w_we_i;
      w_ok_q   <= w_hit & ~w_we_i;
      w_err_q  <= w_req_i & ~w_hit;
      st_rv_q  <= st_valid_i & tx_q;
      st_ok_q  <= st_valid_i & tx_q & st_any;
      st_idx_q <= st_idx;
    end
  end

  assign m_rvalid_o  = m_rv_q;
  assign m_err_o     = m_err_q;
  assign m_rdata_o   = m_ok_q ? bank_rdata[m_bank_q] : '0;
  assign w_rvalid_o  = w_rv_q;
  assign w_err_o     = w_err_q;
  assign st_rvalid_o = st_rv_q;
  assign st_rdata_o  = st_ok_q ? bank_rdata[st_idx_q] : '0;
endmodule

// File: rtl/mbank_router_chk.sv
module mbank_router_chk
  import mbr_pkg::*;
#(
  parameter int NB  = 9,
  parameter int AW  = 4,
  parameter int DW  = 16,
  localparam int BSW = $clog2(NB),
  localparam int MAW = 2 + BSW + AW
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   m_req_i,
  input logic                   m_we_i,
  input logic [MAW-1:0]         m_addr_i,
  input logic [DW-1:0]          m_rdata_o,
  input logic                   m_rvalid_o,
  input logic                   m_err_o,
  input logic [NB-1:1]          w_req_i,
  input logic [NB-1:1][MAW-1:0] w_addr_i,
  input logic [NB-1:1]          w_err_o,
  input logic                   st_valid_i,
  input logic                   st_rvalid_o,
  input logic                   cfg_err_o,
  input logic [NB-1:0][1:0]     mode_q,
  input logic                   tx_q
);
  logic          busy;
  logic [NB-1:0] smask;
  logic [NB-1:1] w_bad;

  assign busy = m_req_i | (|w_req_i) | st_valid_i;
  for (genvar b = 0; b < NB; b++) begin : g_s
    assign smask[b] = (mode_q[b] == OWN_STREAM);
  end
  for (genvar n = 1; n < NB; n++) begin : g_w
    assign w_bad[n] = w_req_i[n] && (w_addr_i[n][MAW-1:AW] != '0);
  end

  AST_READ_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_i && !m_we_i) |=> m_rvalid_o); // R2
  AST_WORKER_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|w_bad) |=> ((w_err_o & $past(w_bad)) == $past(w_bad))); // R4
  AST_ERR_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_err_o |-> (m_rdata_o == '0)); // R5
  AST_BC_READ_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_i && !m_we_i && m_addr_i[MAW-1]) |=> (m_err_o && m_rvalid_o && m_rdata_o == '0)); // R8
  AST_TX_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && tx_q) |=> st_rvalid_o); // R10
  AST_TX_SINGLE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_q |-> ($countones(smask) <= 1)); // R11
  AST_REJECT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> $stable(mode_q)); // R11
  AST_NO_SWITCH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(mode_q)); // R12
endmodule

bind mbank_router mbank_router_chk #(.NB(NB), .AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .m_req_i     (m_req_i),
  .m_we_i      (m_we_i),
  .m_addr_i    (m_addr_i),
  .m_rdata_o   (m_rdata_o),
  .m_rvalid_o  (m_rvalid_o),
  .m_err_o     (m_err_o),
  .w_req_i     (w_req_i),
  .w_addr_i    (w_addr_i),
  .w_err_o     (w_err_o),
  .st_valid_i  (st_valid_i),
  .st_rvalid_o (st_rvalid_o),
  .cfg_err_o   (cfg_err_o),
  .mode_q      (mode_q),
  .tx_q        (tx_q)
);

// File: tb/mbank_router_test.sv
module mbank_router_test;
  localparam int NB = 9, AW = 4, DW = 16, BSW = 4, MAW = 2 + BSW + AW, DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                   cfg_valid, cfg_tx, cfg_err;
  logic [NB-1:0][1:0]     cfg_mode;
  logic [NB-1:0]          cfg_bcast;
  logic                   m_req, m_we, m_rvalid, m_err;
  logic [MAW-1:0]         m_addr;
  logic [DW-1:0]          m_wdata, m_rdata;
  logic [NB-1:1]          w_req, w_we, w_rvalid, w_err;
  logic [NB-1:1][MAW-1:0] w_addr;
  logic [NB-1:1][DW-1:0]  w_wdata, w_rdata;
  logic                   st_valid, st_rvalid;
  logic [AW-1:0]          st_addr;
  logic [DW-1:0]          st_wdata, st_rdata;

  mbank_router #(.NB(NB), .AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_valid_i(cfg_valid), .cfg_mode_i(cfg_mode), .cfg_bcast_i(cfg_bcast),
    .cfg_tx_i(cfg_tx), .cfg_err_o(cfg_err),
    .m_req_i(m_req), .m_we_i(m_we), .m_addr_i(m_addr), .m_wdata_i(m_wdata),
    .m_rdata_o(m_rdata), .m_rvalid_o(m_rvalid), .m_err_o(m_err),
    .w_req_i(w_req), .w_we_i(w_we), .w_addr_i(w_addr), .w_wdata_i(w_wdata),
    .w_rdata_o(w_rdata), .w_rvalid_o(w_rvalid), .w_err_o(w_err),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_wdata_i(st_wdata),
    .st_rdata_o(st_rdata), .st_rvalid_o(st_rvalid)
  );

  int checks = 0, errs = 0;
  logic [DW-1:0] em [NB][DEPTH];
  bit            ek [NB][DEPTH];
  logic [1:0]    emode [NB];
  bit            ebc [NB];
  bit            etx;

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit mown(int b);
    return emode[b] == 2'd1 || (b == 0 && emode[b] == 2'd0);
  endfunction

  // all tasks start and end at a falling edge
  task automatic m_op(input bit we, input logic [1:0] rg, input int bk, input int off,
                      input logic [DW-1:0] d, input string tag);
    bit ok;
    int tb;
    ok = (rg == 2'd0) ? mown(0) : (rg == 2'd1) ? (bk < NB && mown(bk)) : we;
    tb = (rg == 2'd0) ? 0 : bk;
    m_req = 1'b1; m_we = we; m_addr = {rg, 4'(bk), 4'(off)}; m_wdata = d;
    @(negedge clk);
    m_req = 1'b0; m_we = 1'b0;
    chk_eq(tag, m_err, !ok);
    chk_eq(tag, m_rvalid, !we);
    if (!we) begin
      if (!ok) chk_eq(tag, m_rdata, 0);
      else if (ek[tb][off]) chk_eq(tag, m_rdata, em[tb][off]);
    end else if (ok) begin
      if (rg < 2'd2) begin
        em[tb][off] = d; ek[tb][off] = 1'b1;
      end else begin
        for (int b = 0; b < NB; b++)
          if (ebc[b] && mown(b) && !(rg == 2'd3 && b == 0)) begin
            em[b][off] = d; ek[b][off] = 1'b1;
          end
      end
    end
  endtask

  task automatic w_op(input int n, input bit we, input bit good, input int off,
                      input logic [DW-1:0] d, input string tag);
    bit ok;
    ok = good && emode[n] == 2'd0;
    w_req[n] = 1'b1; w_we[n] = we; w_wdata[n] = d;
    w_addr[n] = good ? MAW'(off) : {2'b01, 4'd0, 4'(off)};
    @(negedge clk);
    w_req = '0; w_we = '0;
    chk_eq(tag, w_err[n], !ok);
    chk_eq(tag, w_rvalid[n], !we);
    if (!we) begin
      if (!ok) chk_eq(tag, w_rdata[n], 0);
      else if (ek[n][off]) chk_eq(tag, w_rdata[n], em[n][off]);
    end else if (ok) begin
      em[n][off] = d; ek[n][off] = 1'b1;
    end
  endtask

  task automatic s_op(input int off, input logic [DW-1:0] d, input string tag);
    int cnt, idx;
    cnt = 0; idx = 0;
    for (int b = 0; b < NB; b++) if (emode[b] == 2'd2) begin cnt++; idx = b; end
    st_valid = 1'b1; st_addr = AW'(off); st_wdata = d;
    @(negedge clk);
    st_valid = 1'b0;
    chk_eq(tag, st_rvalid, etx);
    if (etx) begin
      if (cnt == 0) chk_eq(tag, st_rdata, 0);
      else if (ek[idx][off]) chk_eq(tag, st_rdata, em[idx][off]);
    end else begin
      for (int b = 0; b < NB; b++)
        if (emode[b] == 2'd2) begin em[b][off] = d; ek[b][off] = 1'b1; end
    end
  endtask

  task automatic cfg_op(input logic [NB-1:0][1:0] md, input logic [NB-1:0] bc,
                        input bit tx, input string tag);
    int cnt;
    bit bad;
    cnt = 0;
    for (int b = 0; b < NB; b++) if (md[b] == 2'd2) cnt++;
    bad = tx && cnt > 1;
    cfg_valid = 1'b1; cfg_mode = md; cfg_bcast = bc; cfg_tx = tx;
    @(negedge clk);
    cfg_valid = 1'b0;
    chk_eq(tag, cfg_err, bad);
    if (!bad) begin
      for (int b = 0; b < NB; b++) begin emode[b] = md[b]; ebc[b] = bc[b]; end
      etx = tx;
    end
  endtask

  function automatic logic [NB-1:0][1:0] all_master();
    logic [NB-1:0][1:0] r;
    for (int b = 0; b < NB; b++) r[b] = 2'd1;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [NB-1:0][1:0] md;
    logic [2:0] sel;
    void'($urandom(32'd20240611));
    cfg_valid = 0; cfg_mode = '0; cfg_bcast = '0; cfg_tx = 0;
    m_req = 0; m_we = 0; m_addr = '0; m_wdata = '0;
    w_req = '0; w_we = '0; w_addr = '0; w_wdata = '0;
    st_valid = 0; st_addr = '0; st_wdata = '0;
    etx = 0;
    for (int b = 0; b < NB; b++) begin
      emode[b] = 2'd0; ebc[b] = 0;
      for (int a = 0; a < DEPTH; a++) ek[b][a] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_eq("R1", m_rvalid, 0); chk_eq("R1", m_err, 0); chk_eq("R1", cfg_err, 0);
    chk_eq("R1", st_rvalid, 0); chk_eq("R1", w_err, 0);
    m_op(1, 2'd0, 0, 2, 16'h1111, "R1");
    m_op(0, 2'd0, 0, 2, 0, "R2");
    m_op(0, 2'd1, 1, 0, 0, "R1");
    w_op(1, 1, 1, 5, 16'h2222, "R4");
    w_op(1, 0, 1, 5, 0, "R4");
    w_op(1, 0, 0, 5, 0, "R4");
    // R5 unowned write leaves data
    m_op(1, 2'd1, 1, 5, 16'hdead, "R5");
    w_op(1, 0, 1, 5, 0, "R5");

    // R3 linear array
    cfg_op(all_master(), '1, 0, "R3");
    for (int b = 0; b < NB; b++) m_op(1, 2'd1, b, 7, DW'(b * 16'h0101), "R3");
    for (int b = 0; b < NB; b++) m_op(0, 2'd1, b, 7, 0, "R3");
    m_op(0, 2'd1, 9, 0, 0, "R3");
    w_op(2, 0, 1, 7, 0, "R5");

    // R6, R7 broadcast windows; R8 reads there
    m_op(1, 2'd2, 0, 7, 16'hbeef, "R6");
    m_op(0, 2'd1, 0, 7, 0, "R6");
    m_op(0, 2'd1, 4, 7, 0, "R6");
    m_op(1, 2'd3, 0, 7, 16'hcafe, "R7");
    m_op(0, 2'd1, 0, 7, 0, "R7");
    m_op(0, 2'd1, 5, 7, 0, "R7");
    m_op(0, 2'd2, 0, 7, 0, "R8");
    m_op(0, 2'd3, 0, 7, 0, "R8");
    m_op(1, 2'd1, 2, 8, 16'h0, "R6");
    cfg_op(all_master(), 9'b000001000, 0, "R6");
    m_op(1, 2'd2, 0, 8, 16'h3333, "R6");
    m_op(0, 2'd1, 2, 8, 0, "R6");
    m_op(0, 2'd1, 3, 8, 0, "R6");

    // R9 receive fan-out
    md = all_master(); md[4] = 2'd2; md[5] = 2'd2;
    cfg_op(md, '0, 0, "R9");
    s_op(3, 16'h5a5a, "R9");
    m_op(0, 2'd1, 4, 3, 0, "R9");
    cfg_op(all_master(), '0, 0, "R9");
    m_op(0, 2'd1, 4, 3, 0, "R9");
    m_op(0, 2'd1, 5, 3, 0, "R9");

    // R10 transmit from one bank
    m_op(1, 2'd1, 6, 1, 16'h6161, "R10");
    md = all_master(); md[6] = 2'd2;
    cfg_op(md, '0, 1, "R10");
    s_op(1, 0, "R10");
    // R11 two transmit sources rejected
    md = all_master(); md[6] = 2'd2; md[7] = 2'd2;
    cfg_op(md, '0, 1, "R11");
    s_op(1, 0, "R11");
    m_op(0, 2'd1, 7, 7, 0, "R11");

    // R12 strobe during an access is deferred
    md = all_master(); md[1] = 2'd0;
    cfg_valid = 1'b1; cfg_mode = md; cfg_bcast = '0; cfg_tx = 0;
    m_req = 1'b1; m_we = 1'b0; m_addr = {2'd1, 4'd1, 4'd7};
    @(negedge clk);
    cfg_valid = 1'b0; m_req = 1'b0;
    chk_eq("R12", m_err, 0);
    chk_eq("R12", m_rdata, em[1][7]);
    for (int b = 0; b < NB; b++) begin emode[b] = md[b]; ebc[b] = 0; end
    etx = 0;
    @(negedge clk);
    m_op(0, 2'd1, 1, 7, 0, "R12");
    w_op(1, 0, 1, 7, 0, "R12");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      sel = 3'($urandom % 8);
      if (sel == 0) begin
        for (int b = 0; b < NB; b++) md[b] = 2'($urandom % 4);
        cfg_op(md, NB'($urandom), bit'($urandom % 2), "R11");
      end else if (sel < 4) begin
        logic [1:0] rg;
        rg = 2'($urandom % 4);
        case (rg)
          2'd0: m_op(bit'($urandom % 2), rg, int'($urandom % 16), int'($urandom % 16), DW'($urandom), "R2");
          2'd1: m_op(bit'($urandom % 2), rg, int'($urandom % 11), int'($urandom % 16), DW'($urandom), "R3");
          2'd2: m_op(bit'($urandom % 2), rg, 0, int'($urandom % 16), DW'($urandom), "R6");
          default: m_op(bit'($urandom % 2), rg, 0, int'($urandom % 16), DW'($urandom), "R7");
        endcase
      end else if (sel < 7) begin
        w_op(1 + int'($urandom % 8), bit'($urandom % 2), ($urandom % 4) != 0,
             int'($urandom % 16), DW'($urandom), "R4");
      end else begin
        s_op(int'($urandom % 16), DW'($urandom), "R10");
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule